// File: doc/BRIEF.md
# Multi-Pipe Shared Packet Buffer Manager

This block manages one on-chip packet memory that two parties share: a processor-side bus and a serial-engine side. The memory is cut into 64-byte blocks. Each pipe gets a region given by a first block and a block count. With double buffering, a pipe gets a second plane of the same size right after the first. The manager holds each pipe's region settings and flags settings that cannot work. It tracks which side owns each buffer plane and moves ownership when a side commits. It also produces the byte address for processor-side accesses.

Three processor access ports can each be steered to any pipe by number. A port is ready only when its pipe is configured correctly and the plane the processor side is currently using is owned by that side. Each access while ready advances the port's byte pointer. A commit passes the plane to the engine side. The engine returns planes by pulsing a completion for a pipe. In double-buffer mode, the processor side and the engine side each step to the other plane after every handover they make.

Top module: `pktbuf_mgr`

## Requirements
- R1: The address of a port is start block × 64, plus the plane offset, plus the port's byte pointer, taken modulo the memory size in bytes (2^ADDR_W). The plane offset is 0 for plane 0 and block count × 64 for plane 1.
- R2: After reset, every pipe has start block 0, block count 1, single buffering, no continuous mode and packet size 64. All planes belong to the processor side, and both sides point at plane 0. A configuration write (cfg_we with cfg_pipe) loads the new settings for that pipe on the next edge and returns that pipe's ownership to this reset state.
- R3: A commit on a ready port hands the processor side's current plane to the engine side on the next edge and clears that port's pointer. If several ports on the same pipe commit in the same cycle, exactly one handover happens.
- R4: An eng_done pulse for a pipe returns the engine side's current plane to the processor side if the engine owns that plane. Otherwise the pulse has no effect.
- R5: With double buffering on, the processor side toggles its plane after each commit handover, and the engine side toggles its plane after each return. With double buffering off, both sides stay on plane 0.
- R6: port_rdy is high exactly when the selected pipe has no configuration error and the processor side's current plane of that pipe is owned by the processor side.
- R7: A selector write (sel_we) binds the port to sel_pipe from the next edge and clears its pointer and its error flag. An access or commit on that port in the same cycle is ignored.
- R8: An access on a ready port increments its pointer by one, modulo 2^ADDR_W. An access or commit on a port that is not ready changes no pointer or ownership and sets the port's sticky port_err.
- R9: cfg_err for a pipe is high when its block count is 0, or when start + count exceeds MEM_BLOCKS. With double buffering on, the count is doubled in this sum.
- R10: cfg_err for a pipe is also high when continuous mode is on and either the packet size is 0 or the region size in bytes (count × 64) is not a whole multiple of the packet size.
- R11: pipe_cpu_side[k] is high when pipe k's processor-side current plane is processor-owned. pipe_eng_held[k] is high when pipe k's engine-side current plane is engine-owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pipe | input | PIPE_W | Pipe being configured |
| cfg_start | input | BLK_W | First block of the region |
| cfg_count | input | BLK_W | Blocks per plane |
| cfg_dbl | input | 1 | Double-buffer enable |
| cfg_cont | input | 1 | Continuous-mode enable |
| cfg_mps | input | MPS_W | Maximum packet size in bytes |
| sel_we | input | NUM_PORTS | Per-port selector write |
| sel_pipe | input | NUM_PORTS*PIPE_W | Per-port pipe number |
| port_acc | input | NUM_PORTS | Per-port byte access |
| port_commit | input | NUM_PORTS | Per-port plane commit |
| eng_done | input | 1 | Engine finished a plane |
| eng_pipe | input | PIPE_W | Pipe for eng_done |
| port_rdy | output | NUM_PORTS | Port holds access right |
| port_addr | output | NUM_PORTS*ADDR_W | Byte address per port |
| port_err | output | NUM_PORTS | Sticky blocked-access flag |
| cfg_err | output | NUM_PIPES | Per-pipe configuration error |
| pipe_cpu_side | output | NUM_PIPES | Processor-side plane free for processor |
| pipe_eng_held | output | NUM_PIPES | Engine-side plane holds data |

## Verification
The hardest state to reach is a double-buffered pipe in which both planes belong to the engine side. In that state the processor's plane pointer and the engine's plane pointer have both wrapped, and every port bound to the pipe is blocked. The stimulus gets there by committing faster than it completes: commits are frequent and engine completions are rare. Several ports are kept on the same pipe so that simultaneous commits and blocked accesses also occur. Occasional reconfiguration with random start, count and packet size exercises the overrun and multiple-of-packet errors against live ownership.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
   localparam int BLK_SHIFT = 6;   // 64-byte blocks
   typedef enum logic {OWN_CPU = 1'b0, OWN_ENG = 1'b1} owner_e;
endpackage

// File: rtl/pktbuf_pipe_cfg.sv
module pktbuf_pipe_cfg #(
   parameter int MEM_BLOCKS = 32,
   parameter int BLK_W      = 6,
   parameter int MPS_W      = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BLK_W-1:0] start_in,
   input  logic [BLK_W-1:0] count_in,
   input  logic             dbl_in,
   input  logic             cont_in,
   input  logic [MPS_W-1:0] mps_in,
   output logic [BLK_W-1:0] start,
   output logic [BLK_W-1:0] count,
   output logic             dbl,
   output logic             err
);
   import pktbuf_pkg::*;
   localparam int SW = BLK_W + 2;
   localparam int BW = BLK_W + BLK_SHIFT;

   if (MPS_W > BW) begin : g_bad_mps
      $error("MPS_W wider than region byte width");
   end

   logic             cont;
   logic [MPS_W-1:0] mps;
   logic [SW-1:0]    span;
   logic [BW-1:0]    bytes;
   logic [BW-1:0]    mps_x;
   logic             mult_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start <= '0;
         count <= BLK_W'(1);
         dbl   <= 1'b0;
         cont  <= 1'b0;
         mps   <= MPS_W'(64);
      end else if (load) begin
         start <= start_in;
         count <= count_in;
         dbl   <= dbl_in;
         cont  <= cont_in;
         mps   <= mps_in;
      end
   end

   always_comb begin
      span     = SW'(start) + (dbl ? (SW'(count) << 1) : SW'(count));
      bytes    = {count, {BLK_SHIFT{1'b0}}};
      mps_x    = BW'(mps);
      mult_bad = (mps == '0) ? 1'b1 : ((bytes % mps_x) != '0);
      err      = (count == '0) || (span > SW'(MEM_BLOCKS)) || (cont && mult_bad);
   end
endmodule

// File: rtl/pktbuf_pipe_own.sv
module pktbuf_pipe_own (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic dbl,
   input  logic cpu_hand,
   input  logic eng_done,
   output logic cpu_plane,
   output logic cpu_side,
   output logic eng_held
);
   import pktbuf_pkg::*;
   owner_e own [2];
   logic   eng_plane;
   logic   cpu_ok, eng_ok;

   assign cpu_ok   = cpu_hand && (own[cpu_plane] == OWN_CPU);
   assign eng_ok   = eng_done && (own[eng_plane] == OWN_ENG);
   assign cpu_side = (own[cpu_plane] == OWN_CPU);
   assign eng_held = (own[eng_plane] == OWN_ENG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own[0]    <= OWN_CPU;
         own[1]    <= OWN_CPU;
         cpu_plane <= 1'b0;
         eng_plane <= 1'b0;
      end else if (clear) begin
         own[0]    <= OWN_CPU;
         own[1]    <= OWN_CPU;
         cpu_plane <= 1'b0;
         eng_plane <= 1'b0;
      end else begin
         if (cpu_ok) begin
            own[cpu_plane] <= OWN_ENG;
            cpu_plane      <= cpu_plane ^ dbl;
         end
         if (eng_ok) begin
            own[eng_plane] <= OWN_CPU;
            eng_plane      <= eng_plane ^ dbl;
         end
      end
   end
endmodule

// File: rtl/pktbuf_port.sv
module pktbuf_port #(
   parameter int NUM_PIPES = 4,
   parameter int BLK_W     = 6,
   parameter int ADDR_W    = 11,
   localparam int PIPE_W   = $clog2(NUM_PIPES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic [PIPE_W-1:0] sel_new,
   input  logic              acc,
   input  logic              commit,
   input  logic [BLK_W-1:0]  start_a  [NUM_PIPES],
   input  logic [BLK_W-1:0]  count_a  [NUM_PIPES],
   input  logic              plane_a  [NUM_PIPES],
   input  logic              side_a   [NUM_PIPES],
   input  logic              err_a    [NUM_PIPES],
   output logic [PIPE_W-1:0] sel,
   output logic              rdy,
   output logic [ADDR_W-1:0] addr,
   output logic              err,
   output logic              hand
);
   import pktbuf_pkg::*;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] base, off;

   always_comb begin
      rdy  = side_a[sel] && !err_a[sel];
      hand = commit && rdy && !sel_we;
      base = ADDR_W'({start_a[sel], {BLK_SHIFT{1'b0}}});
      off  = plane_a[sel] ? ADDR_W'({count_a[sel], {BLK_SHIFT{1'b0}}}) : '0;
      addr = base + off + ptr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= '0;
         ptr <= '0;
         err <= 1'b0;
      end else if (sel_we) begin
         sel <= sel_new;
         ptr <= '0;
         err <= 1'b0;
      end else begin
         if (hand)
            ptr <= '0;
         else if (acc && rdy)
            ptr <= ptr + 1'b1;
         if ((acc || commit) && !rdy)
            err <= 1'b1;
      end
   end
endmodule

// File: rtl/pktbuf_mgr.sv
module pktbuf_mgr #(
   parameter int NUM_PIPES  = 4,
   parameter int NUM_PORTS  = 3,
   parameter int MEM_BLOCKS = 32,
   parameter int MPS_W      = 11,
   localparam int PIPE_W    = $clog2(NUM_PIPES),
   localparam int BLK_W     = $clog2(MEM_BLOCKS + 1),
   localparam int ADDR_W    = $clog2(MEM_BLOCKS * 64)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [PIPE_W-1:0]           cfg_pipe,
   input  logic [BLK_W-1:0]            cfg_start,
   input  logic [BLK_W-1:0]            cfg_count,
   input  logic                        cfg_dbl,
   input  logic                        cfg_cont,
   input  logic [MPS_W-1:0]            cfg_mps,
   input  logic [NUM_PORTS-1:0]        sel_we,
   input  logic [NUM_PORTS*PIPE_W-1:0] sel_pipe,
   input  logic [NUM_PORTS-1:0]        port_acc,
   input  logic [NUM_PORTS-1:0]        port_commit,
   input  logic                        eng_done,
   input  logic [PIPE_W-1:0]           eng_pipe,
   output logic [NUM_PORTS-1:0]        port_rdy,
   output logic [NUM_PORTS*ADDR_W-1:0] port_addr,
   output logic [NUM_PORTS-1:0]        port_err,
   output logic [NUM_PIPES-1:0]        cfg_err,
   output logic [NUM_PIPES-1:0]        pipe_cpu_side,
   output logic [NUM_PIPES-1:0]        pipe_eng_held
);
   if (NUM_PIPES < 2 || (NUM_PIPES & (NUM_PIPES - 1)) != 0) begin : g_bad_pipes
      $error("NUM_PIPES must be a power of two, at least 2");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end

   logic [BLK_W-1:0]  pipe_start_a [NUM_PIPES];
   logic [BLK_W-1:0]  pipe_count_a [NUM_PIPES];
   logic              pipe_dbl_a   [NUM_PIPES];
   logic              pipe_plane_a [NUM_PIPES];
   logic              pipe_side_a  [NUM_PIPES];
   logic              pipe_err_a   [NUM_PIPES];
   logic [NUM_PIPES-1:0] cpu_hand;
   logic [PIPE_W-1:0] port_sel_a   [NUM_PORTS];
   logic [NUM_PORTS-1:0] port_hand;

   for (genvar k = 0; k < NUM_PIPES; k++) begin : g_pipe
      logic load_k;
      logic eng_k;
      assign load_k = cfg_we && (cfg_pipe == PIPE_W'(k));
      assign eng_k  = eng_done && (eng_pipe == PIPE_W'(k));

      pktbuf_pipe_cfg #(.MEM_BLOCKS(MEM_BLOCKS), .BLK_W(BLK_W), .MPS_W(MPS_W)) u_cfg (
         .clk(clk), .rst_n(rst_n), .load(load_k),
         .start_in(cfg_start), .count_in(cfg_count), .dbl_in(cfg_dbl),
         .cont_in(cfg_cont), .mps_in(cfg_mps),
         .start(pipe_start_a[k]), .count(pipe_count_a[k]),
         .dbl(pipe_dbl_a[k]), .err(pipe_err_a[k]));

      pktbuf_pipe_own u_own (
         .clk(clk), .rst_n(rst_n), .clear(load_k), .dbl(pipe_dbl_a[k]),
         .cpu_hand(cpu_hand[k]), .eng_done(eng_k),
         .cpu_plane(pipe_plane_a[k]), .cpu_side(pipe_side_a[k]),
         .eng_held(pipe_eng_held[k]));

      assign cfg_err[k]       = pipe_err_a[k];
      assign pipe_cpu_side[k] = pipe_side_a[k];
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      pktbuf_port #(.NUM_PIPES(NUM_PIPES), .BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_port (
         .clk(clk), .rst_n(rst_n),
         .sel_we(sel_we[p]), .sel_new(sel_pipe[p*PIPE_W +: PIPE_W]),
         .acc(port_acc[p]), .commit(port_commit[p]),
         .start_a(pipe_start_a), .count_a(pipe_count_a),
         .plane_a(pipe_plane_a), .side_a(pipe_side_a), .err_a(pipe_err_a),
         .sel(port_sel_a[p]), .rdy(port_rdy[p]),
         .addr(port_addr[p*ADDR_W +: ADDR_W]),
         .err(port_err[p]), .hand(port_hand[p]));
   end

   // merge commits from all ports bound to a pipe into one handover
   always_comb begin
      cpu_hand = '0;
      for (int p = 0; p < NUM_PORTS; p++)
         if (port_hand[p])
            cpu_hand[port_sel_a[p]] = 1'b1;
   end
endmodule

// File: rtl/pktbuf_mgr_chk.sv
module pktbuf_mgr_chk #(
   parameter int NUM_PIPES = 4,
   parameter int NUM_PORTS = 3,
   parameter int ADDR_W    = 11,
   localparam int PIPE_W   = $clog2(NUM_PIPES)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_we,
   input logic                        eng_done,
   input logic [PIPE_W-1:0]           eng_pipe,
   input logic [NUM_PORTS-1:0]        sel_we,
   input logic [NUM_PORTS-1:0]        port_acc,
   input logic [NUM_PORTS-1:0]        port_commit,
   input logic [NUM_PORTS-1:0]        port_rdy,
   input logic [NUM_PORTS*ADDR_W-1:0] port_addr,
   input logic [NUM_PORTS-1:0]        port_err,
   input logic [NUM_PIPES-1:0]        cfg_err,
   input logic [NUM_PIPES-1:0]        pipe_cpu_side,
   input logic [NUM_PIPES-1:0]        pipe_eng_held,
   input logic [PIPE_W-1:0]           sel_a [NUM_PORTS],
   input logic                        dbl_a [NUM_PIPES]
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pc
      // R6
      rdy_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
         port_rdy[p] |-> (pipe_cpu_side[sel_a[p]] && !cfg_err[sel_a[p]]));
      // R8
      err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (port_err[p] && !sel_we[p]) |=> port_err[p]);
      // R8
      blocked_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!port_rdy[p] && (port_acc[p] || port_commit[p]) && !sel_we[p]) |=> port_err[p]);
      // R8
      blocked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!port_rdy[p] && port_acc[p] && !sel_we[p] && !cfg_we)
         |=> $stable(port_addr[p*ADDR_W +: ADDR_W]));
      // R7
      sel_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
         sel_we[p] |=> !port_err[p]);
      // R3
      commit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (port_commit[p] && port_rdy[p] && !sel_we[p] && !cfg_we && !dbl_a[sel_a[p]])
         |=> !port_rdy[p]);
   end
   for (genvar k = 0; k < NUM_PIPES; k++) begin : g_kc
      // R4
      eng_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (eng_done && eng_pipe == PIPE_W'(k) && pipe_eng_held[k] && !cfg_we && !dbl_a[k])
         |=> pipe_cpu_side[k]);
   end
endmodule

bind pktbuf_mgr pktbuf_mgr_chk #(.NUM_PIPES(NUM_PIPES), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .eng_done(eng_done), .eng_pipe(eng_pipe),
   .sel_we(sel_we), .port_acc(port_acc), .port_commit(port_commit),
   .port_rdy(port_rdy), .port_addr(port_addr), .port_err(port_err),
   .cfg_err(cfg_err), .pipe_cpu_side(pipe_cpu_side), .pipe_eng_held(pipe_eng_held),
   .sel_a(port_sel_a), .dbl_a(pipe_dbl_a));

// File: tb/tb_pktbuf_mgr.sv
module tb_pktbuf_mgr;
   localparam int NP = 4, NQ = 3, MEMB = 32, MPSW = 11;
   localparam int PW = 2, BW = 6, AW = 11;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          cfg_we = 0, cfg_dbl = 0, cfg_cont = 0, eng_done = 0;
   logic [PW-1:0] cfg_pipe = 0, eng_pipe = 0;
   logic [BW-1:0] cfg_start = 0, cfg_count = 0;
   logic [MPSW-1:0] cfg_mps = 0;
   logic [NQ-1:0] sel_we = 0, port_acc = 0, port_commit = 0;
   logic [NQ*PW-1:0] sel_pipe = 0;
   logic [NQ-1:0] port_rdy, port_err;
   logic [NQ*AW-1:0] port_addr;
   logic [NP-1:0] cfg_err, pipe_cpu_side, pipe_eng_held;

   pktbuf_mgr dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pipe(cfg_pipe),
      .cfg_start(cfg_start), .cfg_count(cfg_count), .cfg_dbl(cfg_dbl),
      .cfg_cont(cfg_cont), .cfg_mps(cfg_mps), .sel_we(sel_we), .sel_pipe(sel_pipe),
      .port_acc(port_acc), .port_commit(port_commit), .eng_done(eng_done),
      .eng_pipe(eng_pipe), .port_rdy(port_rdy), .port_addr(port_addr),
      .port_err(port_err), .cfg_err(cfg_err), .pipe_cpu_side(pipe_cpu_side),
      .pipe_eng_held(pipe_eng_held));

   int tests = 0, fails = 0;

   // reference model
   int m_start[NP], m_count[NP], m_mps[NP];
   bit m_dbl[NP], m_cont[NP];
   bit m_own[NP][2];
   int m_cp[NP], m_ep[NP];
   int m_sel[NQ], m_ptr[NQ];
   bit m_err[NQ];

   function automatic bit f_cfgerr(int k);
      int span;
      span = m_start[k] + m_count[k] * (m_dbl[k] ? 2 : 1);
      if (m_count[k] == 0 || span > MEMB) return 1;
      if (m_cont[k] && (m_mps[k] == 0 || ((m_count[k] * 64) % m_mps[k]) != 0)) return 1;
      return 0;
   endfunction

   function automatic bit f_rdy(int p);
      int s = m_sel[p];
      return !f_cfgerr(s) && (m_own[s][m_cp[s]] == 0);
   endfunction

   function automatic int f_addr(int p);
      int s = m_sel[p];
      int off = (m_cp[s] == 1) ? m_count[s] * 64 : 0;
      return (m_start[s] * 64 + off + m_ptr[p]) % (1 << AW);
   endfunction

   task automatic model_reset();
      for (int k = 0; k < NP; k++) begin
         m_start[k] = 0; m_count[k] = 1; m_mps[k] = 64; m_dbl[k] = 0; m_cont[k] = 0;
         m_own[k][0] = 0; m_own[k][1] = 0; m_cp[k] = 0; m_ep[k] = 0;
      end
      for (int p = 0; p < NQ; p++) begin m_sel[p] = 0; m_ptr[p] = 0; m_err[p] = 0; end
   endtask

   task automatic chk(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      for (int p = 0; p < NQ; p++) begin
         chk(port_rdy[p] == f_rdy(p), "R6 ready flag (ownership R2 R3 R4)", port_rdy[p], f_rdy(p));
         chk(int'(port_addr[p*AW +: AW]) == f_addr(p), "R1 address (plane R5, pointer R8 R7)",
             int'(port_addr[p*AW +: AW]), f_addr(p));
         chk(port_err[p] == m_err[p], "R8 sticky error (clear R7)", port_err[p], m_err[p]);
      end
      for (int k = 0; k < NP; k++) begin
         chk(cfg_err[k] == f_cfgerr(k), "R9 R10 config error", cfg_err[k], f_cfgerr(k));
         chk(pipe_cpu_side[k] == !m_own[k][m_cp[k]], "R11 cpu side status",
             pipe_cpu_side[k], !m_own[k][m_cp[k]]);
         chk(pipe_eng_held[k] == m_own[k][m_ep[k]], "R11 engine held status",
             pipe_eng_held[k], m_own[k][m_ep[k]]);
      end
   endtask

   task automatic model_update();
      bit hand[NP];
      bit rdy[NQ];
      bit eok;
      for (int k = 0; k < NP; k++) hand[k] = 0;
      for (int p = 0; p < NQ; p++) rdy[p] = f_rdy(p);
      for (int p = 0; p < NQ; p++) begin
         if (sel_we[p]) begin
            m_sel[p] = int'(sel_pipe[p*PW +: PW]); m_ptr[p] = 0; m_err[p] = 0;
         end else begin
            if (port_commit[p] && rdy[p]) begin hand[m_sel[p]] = 1; m_ptr[p] = 0; end
            else if (port_acc[p] && rdy[p]) m_ptr[p] = (m_ptr[p] + 1) % (1 << AW);
            if ((port_acc[p] || port_commit[p]) && !rdy[p]) m_err[p] = 1;
         end
      end
      for (int k = 0; k < NP; k++) begin
         if (cfg_we && int'(cfg_pipe) == k) begin
            m_start[k] = int'(cfg_start); m_count[k] = int'(cfg_count);
            m_dbl[k] = cfg_dbl; m_cont[k] = cfg_cont; m_mps[k] = int'(cfg_mps);
            m_own[k][0] = 0; m_own[k][1] = 0; m_cp[k] = 0; m_ep[k] = 0;
         end else begin
            eok = eng_done && int'(eng_pipe) == k && m_own[k][m_ep[k]];
            if (hand[k]) begin
               m_own[k][m_cp[k]] = 1;
               if (m_dbl[k]) m_cp[k] ^= 1;
            end
            if (eok) begin
               m_own[k][m_ep[k]] = 0;
               if (m_dbl[k]) m_ep[k] ^= 1;
            end
         end
      end
   endtask

   task automatic step();
      #1 compare();
      model_update();
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0; sel_we = 0; port_acc = 0; port_commit = 0; eng_done = 0;
   endtask

   task automatic cfg(int k, int s, int c, bit d, bit ct, int m);
      cfg_we = 1; cfg_pipe = PW'(k); cfg_start = BW'(s); cfg_count = BW'(c);
      cfg_dbl = d; cfg_cont = ct; cfg_mps = MPSW'(m);
      step();
   endtask

   task automatic sel(int p, int k);
      sel_we[p] = 1; sel_pipe[p*PW +: PW] = PW'(k);
      step();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      model_reset();
      repeat (3) @(negedge clk);
      #1 compare();               // R2 reset state
      rst_n = 1'b1;
      @(negedge clk);

      // R9 R10: error corners
      cfg(3, 0, 0, 0, 0, 64);     // count zero
      cfg(3, 30, 2, 0, 0, 64);    // exactly fills memory
      cfg(3, 30, 2, 1, 0, 64);    // second plane overruns
      cfg(2, 8, 3, 0, 1, 48);     // 192 multiple of 48
      cfg(2, 8, 3, 0, 1, 100);    // not a multiple
      cfg(2, 8, 3, 0, 1, 0);      // zero packet size
      cfg(2, 8, 3, 0, 0, 0);      // mode off: fine

      // R3 R5: double buffer on pipe 1, two ports, simultaneous commits
      cfg(1, 4, 2, 1, 0, 64);
      sel(0, 1); sel(1, 1); sel(2, 2);
      port_acc = 3'b011; step();
      port_acc = 3'b001; step();
      port_commit = 3'b011; step();   // single handover R3
      port_acc = 3'b001; step();      // plane 1 address R5
      port_commit = 3'b001; step();   // both planes to engine
      port_acc = 3'b011; step();      // blocked R8
      eng_done = 1; eng_pipe = 2; step();  // nothing held: ignored R4
      eng_done = 1; eng_pipe = 1; step();
      eng_done = 1; eng_pipe = 1; step();
      eng_done = 1; eng_pipe = 1; step();
      sel_we = 3'b001; sel_pipe[0 +: PW] = 2; port_acc = 3'b001; port_commit = 3'b001; step(); // R7
      cfg(1, 4, 2, 0, 0, 64);         // R2 reload resets ownership

      // mixed random traffic
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 59) == 0) begin
            cfg_we = 1; cfg_pipe = PW'($urandom_range(0, NP - 1));
            cfg_start = BW'($urandom_range(0, 34)); cfg_count = BW'($urandom_range(0, 12));
            cfg_dbl = 1'($urandom_range(0, 1)); cfg_cont = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 4))
               0: cfg_mps = 0; 1: cfg_mps = 32; 2: cfg_mps = 48; 3: cfg_mps = 64; default: cfg_mps = 100;
            endcase
         end
         for (int p = 0; p < NQ; p++) begin
            if ($urandom_range(0, 24) == 0) begin
               sel_we[p] = 1; sel_pipe[p*PW +: PW] = PW'($urandom_range(0, 1));
            end
            port_acc[p]    = ($urandom_range(0, 1) == 0);
            port_commit[p] = ($urandom_range(0, 4) == 0);
         end
         eng_done = ($urandom_range(0, 5) == 0);
         eng_pipe = PW'($urandom_range(0, NP - 1));
         step();
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule